// File: doc/BRIEF.md
# System Clock Control and Prescaler

This block owns the two 8-bit clock control registers of a small controller and turns the oscillator activity it sees into a CPU clock. Both oscillators arrive as single-cycle edge pulses in the block's sampling clock domain: `main_tick_i` for the main oscillator and `sub_tick_i` for the sub oscillator. The CPU clock leaves the block as a one-cycle pulse, `cpu_tick_o`. The CPU clock comes from either oscillator. On the main path a prescaler divides by 1, 2, 4, 8 or 16. A forcing bit selects divide-by-8 no matter what the ratio field holds.

A protect input decides whether register writes are accepted. Software uses the registers to do five things: pick what the clock-out pin carries, gate the peripheral clocks while the core waits, start and stop the oscillators, set their drive strength, and enter stop mode. Entering stop mode raises some drive and divider bits, and which ones depends on whether the main or the sub oscillator is clocking the CPU. A wake-up input leaves stop mode.

A new divider ratio or clock source takes effect only at the end of a divided period, so no CPU clock period is cut short.

Top module: `sysclk_ctrl`

## Requirements
- R1: While `prot_en_i` is 0, a write to either control register (address 6 for CR0, address 7 for CR1) leaves both registers unchanged.
- R2: After reset, CR0 reads 0x48 and CR1 reads 0x20.
- R3: With CR0 bit 6 at 0 and the main oscillator as source, CR1 bits 7:6 set the ratio of main ticks per CPU tick: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16.
- R4: With CR0 bit 6 at 1, the ratio is 8 whatever CR1 bits 7:6 hold.
- R5: CR0 bit 7 chooses the CPU clock source, 0 for main and 1 for sub. A CR0 write that would change bit 7 and bit 4 together keeps the old bit 7 and still applies its other bits.
- R6: `main_osc_en_o` is the inverse of CR0 bit 5 and `sub_osc_en_o` follows CR0 bit 4, both forced low in stop mode. `sub_drive_hi_o` follows CR0 bit 3 and `main_drive_hi_o` follows CR1 bit 5.
- R7: Writing 1 to CR1 bit 0 enters stop mode. Stop mode holds `cpu_tick_o`, `fc_clk_en_o`, `per_clk_en_o` and `clkout_o` low.
- R8: Entering stop mode sets CR0 bit 3. If CR0 bit 7 was 0 at entry, it also sets CR0 bit 6 and CR1 bit 5. If CR0 bit 7 was 1, those two bits keep their values.
- R9: `wake_i` clears CR1 bit 0. If `wake_i` and a stop-entering write fall in the same cycle, the write's other bits land, but stop mode is not entered and none of the R8 changes happen.
- R10: While `wait_req_i` is 1 and CR0 bit 2 is 1, `per_clk_en_o` is low and `fc_clk_en_o` stays high. While CR0 bit 2 is 0, `per_clk_en_o` stays high whatever `wait_req_i` is.
- R11: CR1 bits 3:1 always read 0, and CR1 bit 4 reads back as written.
- R12: CR0 bits 1:0 select `clkout_o`: 00 gives 0, 01 gives the sub tick, 10 gives the main tick, and 11 gives the CPU tick.
- R13: A change of ratio or source takes effect only at the end of the current divided period, so that period keeps the ratio it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| prot_en_i | input | 1 | Write-protect release, 1 allows writes |
| rdata_o | output | 8 | Read data for addr_i |
| main_tick_i | input | 1 | Main oscillator edge pulse |
| sub_tick_i | input | 1 | Sub oscillator edge pulse |
| wait_req_i | input | 1 | Core is in wait mode |
| wake_i | input | 1 | Wake-up from stop mode |
| cpu_tick_o | output | 1 | CPU clock pulse |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| fc_clk_en_o | output | 1 | Enable for clocks derived from the sub oscillator |
| clkout_o | output | 1 | Clock-out pin value |
| main_osc_en_o | output | 1 | Main oscillator run enable |
| sub_osc_en_o | output | 1 | Sub oscillator run enable |
| main_drive_hi_o | output | 1 | Main oscillator high drive |
| sub_drive_hi_o | output | 1 | Sub oscillator high drive |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a wake-up and a stop-entering write to CR1. The bench raises `wake_i` on the same edge as the write and then reads both registers. A correct design leaves the stop bit clear and applies none of the stop-entry bit changes.

The second pair is a ratio change and a running divided period. The bench writes a new ratio partway through a divide-by-16 period and judges the position of the next CPU tick. That tick must still fall 16 main ticks after the period started.

// File: rtl/sysclk_ctrl_pkg.sv
package sysclk_ctrl_pkg;

   localparam int CC_DW = 8;

   // CR0 layout: fields decoded by the divider and output stage
   typedef struct packed {
      logic       src_sub;    // 7: CPU clock from sub oscillator
      logic       div8;       // 6: force divide-by-8
      logic       main_off;   // 5: main oscillator stopped
      logic       sub_on;     // 4: sub oscillator enabled
      logic       sub_drv;    // 3: sub oscillator high drive
      logic       wait_gate;  // 2: gate peripheral clocks in wait
      logic [1:0] cko_sel;    // 1:0 clock-out source
   } ccr0_t;

   // CR1 layout
   typedef struct packed {
      logic [1:0] div;        // 7:6 ratio code
      logic       main_drv;   // 5: main oscillator high drive
      logic       fc_sel;     // 4: stored select bit
      logic [2:0] rsv;        // 3:1 reserved, zero
      logic       stop;       // 0: stop mode
   } ccr1_t;

   typedef enum logic [1:0] {
      CKO_PORT = 2'b00,
      CKO_SUB  = 2'b01,
      CKO_MAIN = 2'b10,
      CKO_DIV  = 2'b11
   } cko_e;

   // divide ratio minus one
   function automatic logic [3:0] div_limit(input logic force8, input logic [1:0] code);
      logic [3:0] lim;
      if (force8) begin
         lim = 4'd7;
      end else begin
         unique case (code)
            2'b00:   lim = 4'd0;
            2'b01:   lim = 4'd1;
            2'b10:   lim = 4'd3;
            default: lim = 4'd15;
         endcase
      end
      return lim;
   endfunction

endpackage

// File: rtl/sysclk_ctrl_regs.sv
module sysclk_ctrl_regs
   import sysclk_ctrl_pkg::*;
#(
   parameter int          ADDR_W  = 4,
   parameter int          R0_ADDR = 6,
   parameter int          R1_ADDR = 7,
   parameter logic [7:0]  R0_RST  = 8'h48,
   parameter logic [7:0]  R1_RST  = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CC_DW-1:0]  wdata,
   input  logic              we,
   input  logic              prot_en,
   input  logic              wake,
   output logic [CC_DW-1:0]  rdata,
   output ccr0_t             r0_o,
   output ccr1_t             r1_o
);

   localparam logic [ADDR_W-1:0] A0 = ADDR_W'(R0_ADDR);
   localparam logic [ADDR_W-1:0] A1 = ADDR_W'(R1_ADDR);

   generate
      if (R0_ADDR == R1_ADDR) begin : g_bad_addr
         $error("register addresses must differ");
      end
      if (R0_ADDR >= (1 << ADDR_W) || R1_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("register address exceeds address width");
      end
   endgenerate

   ccr0_t r0_q, r0_d;
   ccr1_t r1_q, r1_d;
   logic  wr0, wr1, stop_entry;

   always_comb begin
      wr0        = we && prot_en && (addr == A0);
      wr1        = we && prot_en && (addr == A1);
      r0_d       = r0_q;
      r1_d       = r1_q;
      if (wr0) begin
         r0_d = ccr0_t'(wdata);
         // source and sub enable may not change in one write
         if ((wdata[7] != r0_q.src_sub) && (wdata[4] != r0_q.sub_on))
            r0_d.src_sub = r0_q.src_sub;
      end
      if (wr1) begin
         r1_d     = ccr1_t'(wdata);
         r1_d.rsv = '0;
      end
      stop_entry = wr1 && wdata[0] && !r1_q.stop && !wake;
      if (stop_entry) begin
         r0_d.sub_drv = 1'b1;
         if (!r0_q.src_sub) begin
            r0_d.div8     = 1'b1;
            r1_d.main_drv = 1'b1;
         end
      end
      if (wake) r1_d.stop = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r0_q <= ccr0_t'(R0_RST);
         r1_q <= ccr1_t'(R1_RST & 8'hF1);
      end else begin
         r0_q <= r0_d;
         r1_q <= r1_d;
      end
   end

   always_comb begin
      if (addr == A0)      rdata = r0_q;
      else if (addr == A1) rdata = r1_q;
      else                 rdata = '0;
   end

   assign r0_o = r0_q;
   assign r1_o = r1_q;

   AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !prot_en) |=> ($stable(r0_q) && $stable(r1_q[7:1]))); // R1

   AST_SRC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && prot_en && addr == A0 && wdata[7] != r0_q.src_sub && wdata[4] != r0_q.sub_on)
      |=> $stable(r0_q.src_sub)); // R5

   AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !r1_q.stop); // R9

   AST_LOW_SPEED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (we && prot_en && addr == A1 && wdata[0] && !r1_q.stop && !wake && r0_q.src_sub)
      |=> ($stable(r0_q.div8) && r0_q.sub_drv)); // R8

endmodule

// File: rtl/sysclk_ctrl_div.sv
module sysclk_ctrl_div
   import sysclk_ctrl_pkg::*;
#(
   parameter int         CNT_W   = 4,
   parameter logic [3:0] RST_LIM = 4'd7,
   parameter logic       RST_SUB = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic main_tick,
   input  logic sub_tick,
   input  logic stop,
   input  logic src_sub_req,
   input  logic div8_req,
   input  logic [1:0] div_req,
   output logic cpu_tick
);

   generate
      if (CNT_W < 4) begin : g_bad_cnt
         $error("counter too narrow for divide-by-16");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, lim_q, lim_req;
   logic             sub_q, src_tick, at_end;

   assign lim_req  = CNT_W'(div_limit(div8_req, div_req));
   assign src_tick = sub_q ? sub_tick : main_tick;
   assign at_end   = sub_q || (cnt_q == lim_q);
   assign cpu_tick = !stop && src_tick && at_end;

   // settings load only at the end of a divided period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= CNT_W'(RST_LIM);
         sub_q <= RST_SUB;
      end else if (stop) begin
         cnt_q <= '0;
      end else if (src_tick) begin
         if (at_end) begin
            cnt_q <= '0;
            lim_q <= lim_req;
            sub_q <= src_sub_req;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_tick |=> ($stable(lim_q) && $stable(sub_q))); // R13

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim_q); // R3

endmodule

// File: rtl/sysclk_ctrl_out.sv
module sysclk_ctrl_out
   import sysclk_ctrl_pkg::*;
#(
   parameter bit CKO_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cko_sel,
   input  logic       main_tick,
   input  logic       sub_tick,
   input  logic       cpu_tick,
   input  logic       stop,
   input  logic       wait_req,
   input  logic       wait_gate,
   output logic       clkout,
   output logic       per_en,
   output logic       fc_en
);

   logic cko_d;

   always_comb begin
      unique case (cko_e'(cko_sel))
         CKO_SUB:  cko_d = sub_tick && !stop;
         CKO_MAIN: cko_d = main_tick && !stop;
         CKO_DIV:  cko_d = cpu_tick;
         default:  cko_d = 1'b0;
      endcase
   end

   generate
      if (CKO_REG) begin : g_cko_reg
         logic cko_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cko_q <= 1'b0;
            else        cko_q <= cko_d;
         end
         assign clkout = cko_q;
      end else begin : g_cko_comb
         assign clkout = cko_d;
      end
   endgenerate

   assign fc_en  = !stop;
   assign per_en = !stop && !(wait_req && wait_gate);

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
   import sysclk_ctrl_pkg::*;
#(
   parameter int         ADDR_W  = 4,
   parameter int         R0_ADDR = 6,
   parameter int         R1_ADDR = 7,
   parameter logic [7:0] R0_RST  = 8'h48,
   parameter logic [7:0] R1_RST  = 8'h20,
   parameter int         CNT_W   = 4,
   parameter bit         CKO_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   input  logic              we_i,
   input  logic              prot_en_i,
   output logic [7:0]        rdata_o,
   input  logic              main_tick_i,
   input  logic              sub_tick_i,
   input  logic              wait_req_i,
   input  logic              wake_i,
   output logic              cpu_tick_o,
   output logic              per_clk_en_o,
   output logic              fc_clk_en_o,
   output logic              clkout_o,
   output logic              main_osc_en_o,
   output logic              sub_osc_en_o,
   output logic              main_drive_hi_o,
   output logic              sub_drive_hi_o
);

   localparam logic [3:0] RST_LIM = div_limit(R0_RST[6], R1_RST[7:6]);

   ccr0_t r0;
   ccr1_t r1;
   logic  stop;

   sysclk_ctrl_regs #(
      .ADDR_W(ADDR_W), .R0_ADDR(R0_ADDR), .R1_ADDR(R1_ADDR),
      .R0_RST(R0_RST), .R1_RST(R1_RST)
   ) i_regs (
      .clk(clk_i), .rst_n(rst_ni), .addr(addr_i), .wdata(wdata_i),
      .we(we_i), .prot_en(prot_en_i), .wake(wake_i), .rdata(rdata_o),
      .r0_o(r0), .r1_o(r1)
   );

   assign stop = r1.stop;

   sysclk_ctrl_div #(
      .CNT_W(CNT_W), .RST_LIM(RST_LIM), .RST_SUB(R0_RST[7])
   ) i_div (
      .clk(clk_i), .rst_n(rst_ni), .main_tick(main_tick_i), .sub_tick(sub_tick_i),
      .stop(stop), .src_sub_req(r0.src_sub), .div8_req(r0.div8),
      .div_req(r1.div), .cpu_tick(cpu_tick_o)
   );

   sysclk_ctrl_out #(
      .CKO_REG(CKO_REG)
   ) i_out (
      .clk(clk_i), .rst_n(rst_ni), .cko_sel(r0.cko_sel), .main_tick(main_tick_i),
      .sub_tick(sub_tick_i), .cpu_tick(cpu_tick_o), .stop(stop),
      .wait_req(wait_req_i), .wait_gate(r0.wait_gate),
      .clkout(clkout_o), .per_en(per_clk_en_o), .fc_en(fc_clk_en_o)
   );

   assign main_osc_en_o   = !r0.main_off && !stop;
   assign sub_osc_en_o    = r0.sub_on && !stop;
   assign main_drive_hi_o = r1.main_drv;
   assign sub_drive_hi_o  = r0.sub_drv;

   AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      r1.stop |-> (!cpu_tick_o && !main_osc_en_o && !per_clk_en_o)); // R7

   AST_WAIT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wait_req_i && r0.wait_gate) |-> !per_clk_en_o); // R10

endmodule

// File: tb/test_sysclk_ctrl.sv
module test_sysclk_ctrl;

   localparam time PER = 10ns;
   localparam logic [3:0] A0 = 4'd6;
   localparam logic [3:0] A1 = 4'd7;

   // {cr0 write, cr1 write, cr1 readback, CPU ticks in 48 main ticks}
   localparam logic [31:0] VEC [7] = '{
      {8'h00, 8'h00, 8'h00, 8'd48},
      {8'h00, 8'h4E, 8'h40, 8'd24},
      {8'h00, 8'h80, 8'h80, 8'd12},
      {8'h00, 8'hD0, 8'hD0, 8'd3},
      {8'h40, 8'h00, 8'h00, 8'd6},
      {8'h40, 8'hC0, 8'hC0, 8'd6},
      {8'h00, 8'h8E, 8'h80, 8'd12}
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0, rdata;
   logic       we = 1'b0, prot = 1'b1, main_t = 1'b0, sub_t = 1'b0, wait_r = 1'b0, wake = 1'b0;
   logic       cpu_t, per_en, fc_en, cko, mosc, sosc, mdrv, sdrv;
   int         checks = 0, errors = 0;

   always #(PER/2) clk = ~clk;

   sysclk_ctrl i_sysclk_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
      .prot_en_i(prot), .rdata_o(rdata), .main_tick_i(main_t), .sub_tick_i(sub_t),
      .wait_req_i(wait_r), .wake_i(wake), .cpu_tick_o(cpu_t), .per_clk_en_o(per_en),
      .fc_clk_en_o(fc_en), .clkout_o(cko), .main_osc_en_o(mosc), .sub_osc_en_o(sosc),
      .main_drive_hi_o(mdrv), .sub_drive_hi_o(sdrv)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic wait_tick(input string req);
      bit seen = 1'b0;
      for (int i = 0; i < 100; i++) begin
         @(posedge clk); #1;
         if (cpu_t) begin seen = 1'b1; break; end
      end
      chk(req, 32'(seen), 32'd1);
   endtask

   task automatic count_ticks(input int n, input int sub_every, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (sub_every > 0) sub_t = (i % sub_every == 0);
         @(posedge clk); #1;
         if (cpu_t) cnt++;
      end
      @(negedge clk); sub_t = 1'b0;
   endtask

   initial begin
      #(PER * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int n, first;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset values, R6 reset outputs
      rd(A0, v); chk("R2 cr0 reset", v, 8'h48);
      rd(A1, v); chk("R2 cr1 reset", v, 8'h20);
      chk("R6 main osc en", mosc, 1);
      chk("R6 sub osc en", sosc, 0);
      chk("R6 main drive", mdrv, 1);
      chk("R6 sub drive", sdrv, 1);

      // R1 protect gate
      prot = 1'b0;
      wr(A0, 8'h00); wr(A1, 8'hC0);
      rd(A0, v); chk("R1 cr0 protected", v, 8'h48);
      rd(A1, v); chk("R1 cr1 protected", v, 8'h20);
      prot = 1'b1;

      // R3 R4 R11 ratio table
      main_t = 1'b1;
      foreach (VEC[k]) begin
         wr(A0, VEC[k][31:24]);
         wr(A1, VEC[k][23:16]);
         rd(A1, v); chk("R11 cr1 readback", v, VEC[k][15:8]);
         wait_tick("R3 boundary");
         count_ticks(48, 0, n);
         chk(VEC[k][31:24] == 8'h40 ? "R4 forced ratio" : "R3 ratio", n, VEC[k][7:0]);
      end

      // R13 ratio change mid-period
      wr(A0, 8'h00); wr(A1, 8'hC0);
      wait_tick("R13 boundary");
      wait_tick("R13 boundary");
      first = 0;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (k == 4) begin addr = A1; wdata = 8'h00; we = 1'b1; end
         else we = 1'b0;
         @(posedge clk); #1;
         if (cpu_t && first == 0) first = k;
      end
      chk("R13 period kept", first, 16);

      // R5 source guard and sub clock source
      wr(A0, 8'h00);
      wr(A0, 8'h90);
      rd(A0, v); chk("R5 bit7 rejected", v, 8'h10);
      wr(A0, 8'h90);
      rd(A0, v); chk("R5 bit7 accepted", v, 8'h90);
      repeat (3) @(negedge clk);
      count_ticks(30, 3, n);
      chk("R5 sub source ticks", n, 10);

      // R8 stop from low speed, R7 quiet
      wr(A1, 8'h01);
      rd(A0, v); chk("R8 low speed cr0", v, 8'h98);
      rd(A1, v); chk("R8 low speed cr1", v, 8'h01);
      count_ticks(12, 2, n);
      chk("R7 no cpu ticks", n, 0);
      chk("R7 fc off", fc_en, 0);
      chk("R7 per off", per_en, 0);
      chk("R6 osc off in stop", {mosc, sosc}, 0);
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0;
      rd(A1, v); chk("R9 wake clears", v, 8'h00);

      // R8 stop from high speed
      wr(A0, 8'h18);
      rd(A0, v); chk("R5 back to main", v, 8'h18);
      wr(A1, 8'h01);
      rd(A0, v); chk("R8 high speed cr0", v, 8'h58);
      rd(A1, v); chk("R8 high speed cr1", v, 8'h21);
      chk("R6 main drive after stop", mdrv, 1);
      @(negedge clk); wake = 1'b1;
      @(negedge clk); wake = 1'b0;

      // R9 wake and stop write in one cycle
      wr(A0, 8'h10);
      @(negedge clk); addr = A1; wdata = 8'h01; we = 1'b1; wake = 1'b1;
      @(negedge clk); we = 1'b0; wake = 1'b0;
      rd(A1, v); chk("R9 same-cycle cr1", v, 8'h00);
      rd(A0, v); chk("R9 same-cycle cr0", v, 8'h10);

      // R6 oscillator enables
      wr(A0, 8'h30);
      chk("R6 main stopped", mosc, 0);
      chk("R6 sub running", sosc, 1);

      // R10 wait gating
      wr(A0, 8'h04);
      @(negedge clk); wait_r = 1'b1; #1;
      chk("R10 per gated", per_en, 0);
      chk("R10 fc kept", fc_en, 1);
      wr(A0, 8'h00); #1;
      chk("R10 per ungated", per_en, 1);
      @(negedge clk); wait_r = 1'b0;

      // R12 clock-out select
      wr(A0, 8'h01);
      @(negedge clk); sub_t = 1'b1; main_t = 1'b0; #1 chk("R12 sub out", cko, 1);
      @(negedge clk); sub_t = 1'b0; main_t = 1'b1; #1 chk("R12 sub out low", cko, 0);
      wr(A0, 8'h02); #1 chk("R12 main out", cko, 1);
      @(negedge clk); sub_t = 1'b1; main_t = 1'b0; #1 chk("R12 main out low", cko, 0);
      wr(A0, 8'h00);
      @(negedge clk); main_t = 1'b1; #1 chk("R12 port sel", cko, 0);
      wr(A0, 8'h03);
      @(negedge clk); sub_t = 1'b0;
      wait_tick("R12 divider out");
      chk("R12 divider out", cko, cpu_t);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule